// File: doc/BRIEF.md
# Reserved-Load / Conditional-Store Coherency Sequencer

This block sits between a processor core and a MESI data cache with a split-transaction system bus. It turns load-reserved and store-conditional requests into bus transfers, picks the new MESI state of the addressed line from the snoop outcome, and reports the result back to the core. A store-conditional can succeed only if a matching reservation is held. The block reports that result as a 4-bit condition field. A load-reserved to a write-through or caching-inhibited page raises an exception instead.

The block holds one reservation: a valid bit and a cache-line address. A load-reserved sets it. Any store-conditional clears it. A snooped transaction from another master that hits the reserved line also clears it. Bus transfers use 5-bit transfer-type codes. A snoop address-retry makes the block give up the bus and reissue the same transfer. Cache arrays, data movement and bus arbitration belong to neighbouring logic.

Top module: `lrsc_coherency_ctrl`

## Requirements
- R1: After reset, `reqReady` is 1, `busReq` and `respValid` are 0, and no reservation is held, so a first store-conditional fails.
- R2: Request op codes are 01 for load-reserved and 10 for store-conditional. A load-reserved to a line in state I (MESI codes I=00, S=01, E=10, M=11) raises `busReq` with `busType` 11010. While `busReq` is high, `busGlobal` equals the request's coherence bit.
- R3: When that read completes with no retry and no shared response, `respValid` pulses with `stateWe`=1 and `stateNew`=E (10), and the reservation is set on that line.
- R4: When that read completes with a shared response, `stateNew` is S (01) and the reservation is set.
- R5: A load-reserved to a line in S, E or M issues no bus transfer. The response comes one cycle after acceptance with `stateWe`=0, and the reservation is set.
- R6: A load-reserved with the write-through or caching-inhibited bit set gives `respValid` with `excFlag`=1, `crWe`=0 and `stateWe`=0. It issues no transfer and leaves the reservation unchanged.
- R7: A store-conditional whose line does not match a held reservation issues no transfer. It responds with `crWe`=1, `crField`=0000 and `stateWe`=0.
- R8: A store-conditional that holds the reservation on a line in state I or S issues `busType` 11110. On completion, with or without shared, it reports success (`crField`=0010, bit 1 being the equal bit) with `stateWe`=1 and `stateNew`=M.
- R9: A store-conditional that holds the reservation on a line in E or M issues no transfer. It reports success with `stateNew`=M.
- R10: A store-conditional with the write-through or caching-inhibited bit set that holds the reservation issues `busType` 10010. On completion it reports success with `stateWe`=0.
- R11: An address-retry, with or without shared, drops the bus request and re-raises it one cycle later with the same code and no response. If a store-conditional has lost its reservation by the time the retry arrives, it instead responds with failure.
- R12: A snoop from another master with `extSnoopValid` high and the reserved line address clears the reservation. A snoop to another line does not.
- R13: Every store-conditional clears the reservation, whether it succeeds or fails.
- R14: Once raised, `busReq` and `busType` stay stable until `busGrant` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request present |
| reqOp | input | 2 | 01 load-reserved, 10 store-conditional |
| reqLine | input | LINE_W | Cache-line address of the request |
| reqWriteThru | input | 1 | Page is write-through |
| reqInhibit | input | 1 | Page is caching-inhibited |
| reqCoherent | input | 1 | Coherence-required attribute |
| lineState | input | 2 | Current MESI state of the line |
| busGrant | input | 1 | Address bus granted |
| snoopDone | input | 1 | Snoop response window for our transfer |
| snoopRetry | input | 1 | Address-retry response |
| snoopShared | input | 1 | Shared response |
| extSnoopValid | input | 1 | Another master's transfer is being snooped |
| extSnoopLine | input | LINE_W | Line address of that transfer |
| reqReady | output | 1 | Idle, request can be accepted |
| busReq | output | 1 | Bus request |
| busType | output | 5 | Transfer-type code |
| busGlobal | output | 1 | Coherence attribute driven with the transfer |
| respValid | output | 1 | One-cycle completion pulse |
| excFlag | output | 1 | Data-storage exception |
| crWe | output | 1 | Condition field write |
| crField | output | 4 | Condition field value |
| stateWe | output | 1 | MESI state write |
| stateNew | output | 2 | New MESI state |

## Verification
The bench builds the block with `LINE_W`=3. With only eight distinct lines, random load-reserved, store-conditional and foreign-snoop traffic hits the reserved line often, so reservation kills and address mismatches happen many times per run. Directed sequences add a reservation lost between grant and a retry, and multiple retries before completion.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    MESI_I = 2'b00,
    MESI_S = 2'b01,
    MESI_E = 2'b10,
    MESI_M = 2'b11
  } mesi_e;

  localparam logic [1:0] OP_LOADRES   = 2'b01;
  localparam logic [1:0] OP_STORECOND = 2'b10;

  localparam logic [4:0] TT_READ_ATOMIC   = 5'b11010;
  localparam logic [4:0] TT_RWITM_ATOMIC  = 5'b11110;
  localparam logic [4:0] TT_WFLUSH_ATOMIC = 5'b10010;

  localparam int CR_W      = 4;
  localparam int CR_EQ_BIT = 1;

  typedef enum logic [1:0] {
    BT_KEEP,
    BT_READ,
    BT_RWITM,
    BT_WFLUSH
  } busSel_e;

  typedef struct packed {
    logic    capture;
    logic    resvSet;
    logic    resvClear;
    logic    busArm;
    busSel_e busSel;
    logic    busDrop;
    logic    respFire;
    logic    respExc;
    logic    respCrWe;
    logic    respCrOk;
    logic    respStWe;
    mesi_e   respStNew;
  } ctrlStrobe_t;

  function automatic logic [4:0] busCode(input busSel_e sel);
    case (sel)
      BT_READ:   busCode = TT_READ_ATOMIC;
      BT_RWITM:  busCode = TT_RWITM_ATOMIC;
      BT_WFLUSH: busCode = TT_WFLUSH_ATOMIC;
      default:   busCode = 5'b00000;
    endcase
  endfunction

endpackage

// File: rtl/lrsc_datapath.sv
module lrsc_datapath
  import lrsc_pkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [LINE_W-1:0]   reqLine,
  input  logic                reqCoherent,
  input  logic                extSnoopValid,
  input  logic [LINE_W-1:0]   extSnoopLine,
  output logic                resvMatchLive,
  output logic                resvMatchHeld,
  output logic                busReq,
  output logic [4:0]          busType,
  output logic                busGlobal,
  output logic                respValid,
  output logic                excFlag,
  output logic                crWe,
  output logic [CR_W-1:0]     crField,
  output logic                stateWe,
  output logic [1:0]          stateNew
);

  logic [LINE_W-1:0] heldLine;
  logic              heldGlobal;
  logic              resvValid;
  logic [LINE_W-1:0] resvLine;
  logic [LINE_W-1:0] setLine;
  logic              snoopHitSet;
  logic              snoopHitResv;

  assign setLine      = strb.capture ? reqLine : heldLine;
  assign snoopHitSet  = extSnoopValid && (extSnoopLine == setLine);
  assign snoopHitResv = extSnoopValid && (extSnoopLine == resvLine);

  assign resvMatchLive = resvValid && (resvLine == reqLine);
  assign resvMatchHeld = resvValid && (resvLine == heldLine);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldLine   <= '0;
      heldGlobal <= 1'b0;
    end else if (strb.capture) begin
      heldLine   <= reqLine;
      heldGlobal <= reqCoherent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvLine  <= '0;
    end else if (strb.resvSet) begin
      resvValid <= !snoopHitSet;
      resvLine  <= setLine;
    end else if (strb.resvClear || snoopHitResv) begin
      resvValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReq    <= 1'b0;
      busType   <= 5'b00000;
      busGlobal <= 1'b0;
    end else if (strb.busArm) begin
      busReq <= 1'b1;
      if (strb.busSel != BT_KEEP) busType <= busCode(strb.busSel);
      busGlobal <= strb.capture ? reqCoherent : heldGlobal;
    end else if (strb.busDrop) begin
      busReq <= 1'b0;
    end
  end

  logic [CR_W-1:0] crValue;
  always_comb begin
    crValue = '0;
    crValue[CR_EQ_BIT] = strb.respCrOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      excFlag   <= 1'b0;
      crWe      <= 1'b0;
      crField   <= '0;
      stateWe   <= 1'b0;
      stateNew  <= 2'b00;
    end else begin
      respValid <= strb.respFire;
      excFlag   <= strb.respFire && strb.respExc;
      crWe      <= strb.respFire && strb.respCrWe;
      crField   <= (strb.respFire && strb.respCrWe) ? crValue : '0;
      stateWe   <= strb.respFire && strb.respStWe;
      stateNew  <= (strb.respFire && strb.respStWe) ? strb.respStNew : MESI_I;
    end
  end

endmodule

// File: rtl/lrsc_control.sv
module lrsc_control
  import lrsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic        reqWriteThru,
  input  logic        reqInhibit,
  input  logic [1:0]  lineState,
  input  logic        busGrant,
  input  logic        snoopDone,
  input  logic        snoopRetry,
  input  logic        snoopShared,
  input  logic        resvMatchLive,
  input  logic        resvMatchHeld,
  output ctrlStrobe_t strb,
  output logic        reqReady
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_ADDR} ctrlState_e;

  ctrlState_e state, stateNext;
  busSel_e    selQ;
  logic       noCache;
  logic       lineValid;
  logic       lineOwned;

  assign noCache   = reqWriteThru || reqInhibit;
  assign lineValid = (lineState != MESI_I);
  assign lineOwned = (lineState == MESI_E) || (lineState == MESI_M);
  assign reqReady  = (state == ST_IDLE);

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid && reqOp == OP_LOADRES) begin
          strb.capture = 1'b1;
          if (noCache) begin
            strb.respFire = 1'b1;
            strb.respExc  = 1'b1;
          end else if (lineValid) begin
            strb.resvSet  = 1'b1;
            strb.respFire = 1'b1;
          end else begin
            strb.busArm = 1'b1;
            strb.busSel = BT_READ;
            stateNext   = ST_ARB;
          end
        end else if (reqValid && reqOp == OP_STORECOND) begin
          strb.capture = 1'b1;
          if (!resvMatchLive) begin
            strb.resvClear = 1'b1;
            strb.respFire  = 1'b1;
            strb.respCrWe  = 1'b1;
          end else if (noCache) begin
            strb.busArm = 1'b1;
            strb.busSel = BT_WFLUSH;
            stateNext   = ST_ARB;
          end else if (lineOwned) begin
            strb.resvClear = 1'b1;
            strb.respFire  = 1'b1;
            strb.respCrWe  = 1'b1;
            strb.respCrOk  = 1'b1;
            strb.respStWe  = 1'b1;
            strb.respStNew = MESI_M;
          end else begin
            strb.busArm = 1'b1;
            strb.busSel = BT_RWITM;
            stateNext   = ST_ARB;
          end
        end
      end
      ST_ARB: begin
        if (busGrant) begin
          strb.busDrop = 1'b1;
          stateNext    = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (snoopDone) begin
          if (snoopRetry) begin
            if (selQ != BT_READ && !resvMatchHeld) begin
              strb.resvClear = 1'b1;
              strb.respFire  = 1'b1;
              strb.respCrWe  = 1'b1;
              stateNext      = ST_IDLE;
            end else begin
              strb.busArm = 1'b1;
              strb.busSel = BT_KEEP;
              stateNext   = ST_ARB;
            end
          end else begin
            strb.respFire = 1'b1;
            stateNext     = ST_IDLE;
            case (selQ)
              BT_READ: begin
                strb.resvSet   = 1'b1;
                strb.respStWe  = 1'b1;
                strb.respStNew = snoopShared ? MESI_S : MESI_E;
              end
              BT_RWITM: begin
                strb.resvClear = 1'b1;
                strb.respCrWe  = 1'b1;
                strb.respCrOk  = 1'b1;
                strb.respStWe  = 1'b1;
                strb.respStNew = MESI_M;
              end
              default: begin
                strb.resvClear = 1'b1;
                strb.respCrWe  = 1'b1;
                strb.respCrOk  = 1'b1;
              end
            endcase
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      selQ  <= BT_KEEP;
    end else begin
      state <= stateNext;
      if (strb.busArm && strb.busSel != BT_KEEP) selQ <= strb.busSel;
    end
  end

endmodule

// File: rtl/lrsc_coherency_ctrl.sv
module lrsc_coherency_ctrl
  import lrsc_pkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              reqWriteThru,
  input  logic              reqInhibit,
  input  logic              reqCoherent,
  input  logic [1:0]        lineState,
  input  logic              busGrant,
  input  logic              snoopDone,
  input  logic              snoopRetry,
  input  logic              snoopShared,
  input  logic              extSnoopValid,
  input  logic [LINE_W-1:0] extSnoopLine,
  output logic              reqReady,
  output logic              busReq,
  output logic [4:0]        busType,
  output logic              busGlobal,
  output logic              respValid,
  output logic              excFlag,
  output logic              crWe,
  output logic [3:0]        crField,
  output logic              stateWe,
  output logic [1:0]        stateNew
);

  ctrlStrobe_t strb;
  logic        resvMatchLive;
  logic        resvMatchHeld;

  lrsc_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqWriteThru (reqWriteThru),
    .reqInhibit   (reqInhibit),
    .lineState    (lineState),
    .busGrant     (busGrant),
    .snoopDone    (snoopDone),
    .snoopRetry   (snoopRetry),
    .snoopShared  (snoopShared),
    .resvMatchLive(resvMatchLive),
    .resvMatchHeld(resvMatchHeld),
    .strb         (strb),
    .reqReady     (reqReady)
  );

  lrsc_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqLine      (reqLine),
    .reqCoherent  (reqCoherent),
    .extSnoopValid(extSnoopValid),
    .extSnoopLine (extSnoopLine),
    .resvMatchLive(resvMatchLive),
    .resvMatchHeld(resvMatchHeld),
    .busReq       (busReq),
    .busType      (busType),
    .busGlobal    (busGlobal),
    .respValid    (respValid),
    .excFlag      (excFlag),
    .crWe         (crWe),
    .crField      (crField),
    .stateWe      (stateWe),
    .stateNew     (stateNew)
  );

endmodule

// File: rtl/lrsc_checker.sv
module lrsc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       busReq,
  input logic       busGrant,
  input logic [4:0] busType,
  input logic       respValid,
  input logic       excFlag,
  input logic       crWe,
  input logic [3:0] crField,
  input logic       stateWe,
  input logic [1:0] stateNew
);

  a_r14_hold_until_grant: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGrant |=> busReq && $stable(busType));

  a_r1_busy_while_requesting: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !reqReady);

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busType == 5'b11010 || busType == 5'b11110 || busType == 5'b10010));

  a_r6_exception_alone: assert property (@(posedge clk) disable iff (!rstN)
    respValid && excFlag |-> !crWe && !stateWe);

  a_r7_cr_shape: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> crField[3:2] == 2'b00 && !crField[0]);

  a_r8_success_modifies: assert property (@(posedge clk) disable iff (!rstN)
    respValid && crWe && crField[1] && stateWe |-> stateNew == 2'b11);

  a_r3_quiet_without_response: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !crWe && !stateWe && !excFlag);

endmodule

bind lrsc_coherency_ctrl lrsc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .busReq   (busReq),
  .busGrant (busGrant),
  .busType  (busType),
  .respValid(respValid),
  .excFlag  (excFlag),
  .crWe     (crWe),
  .crField  (crField),
  .stateWe  (stateWe),
  .stateNew (stateNew)
);

// File: tb/tb_lrsc_coherency_ctrl.sv
module tb_lrsc_coherency_ctrl;

  localparam int LW = 3;
  localparam logic [1:0] LR = 2'b01, SC = 2'b10;
  localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWriteThru = 0, reqInhibit = 0, reqCoherent = 0;
  logic [1:0] reqOp = 0, lineState = 0;
  logic [LW-1:0] reqLine = 0, extSnoopLine = 0;
  logic busGrant = 0, snoopDone = 0, snoopRetry = 0, snoopShared = 0, extSnoopValid = 0;
  logic reqReady, busReq, busGlobal, respValid, excFlag, crWe, stateWe;
  logic [4:0] busType;
  logic [3:0] crField;
  logic [1:0] stateNew;

  int checks = 0, errors = 0;
  bit mResv = 0;
  logic [LW-1:0] mLine = 0;

  always #2.5 clk = ~clk;

  lrsc_coherency_ctrl #(.LINE_W(LW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkResp(input bit eExc, input bit eCrWe, input bit eOk,
                         input bit eStWe, input logic [1:0] eSt, input string tag);
    chk(respValid == 1'b1, tag, respValid, 1);
    chk(excFlag == eExc, tag, excFlag, eExc);
    chk(crWe == eCrWe, tag, crWe, eCrWe);
    if (eCrWe) chk(crField == (eOk ? 4'b0010 : 4'b0000), tag, crField, eOk ? 2 : 0);
    chk(stateWe == eStWe, tag, stateWe, eStWe);
    if (eStWe) chk(stateNew == eSt, tag, stateNew, eSt);
  endtask

  task automatic snoopOther(input logic [LW-1:0] l);
    extSnoopValid = 1; extSnoopLine = l;
    @(negedge clk);
    extSnoopValid = 0;
    if (mResv && mLine == l) mResv = 0;  // R12
  endtask

  task automatic runReq(input logic [1:0] op, input logic [LW-1:0] line, input bit wt,
                        input bit inh, input bit coh, input logic [1:0] st,
                        input int nRetry, input bit shrd, input bit killOnGrant);
    bit match = mResv && mLine == line;
    logic [4:0] code = 0;
    string tag = "R5";
    if (op == LR) begin
      if (wt || inh) tag = "R6";
      else if (st == SI) begin code = 5'b11010; tag = shrd ? "R4" : "R3"; end
    end else begin
      if (!match) tag = "R7";
      else if (wt || inh) begin code = 5'b10010; tag = "R10"; end
      else if (st == SE || st == SM) tag = "R9";
      else begin code = 5'b11110; tag = "R8"; end
    end
    reqValid = 1; reqOp = op; reqLine = line; reqWriteThru = wt;
    reqInhibit = inh; reqCoherent = coh; lineState = st;
    @(negedge clk);
    reqValid = 0;
    if (code == 0) begin
      case (tag)
        "R6": chkResp(1, 0, 0, 0, SI, tag);
        "R5": begin chkResp(0, 0, 0, 0, SI, tag); mResv = 1; mLine = line; end
        "R7": begin chkResp(0, 1, 0, 0, SI, tag); mResv = 0; end
        default: begin chkResp(0, 1, 1, 1, SM, tag); mResv = 0; end
      endcase
      chk(busReq == 0, tag, busReq, 0);
    end else begin
      chk(busReq == 1 && busType == code, "R2", busType, code);
      chk(busGlobal == coh, "R2", busGlobal, coh);
      for (int r = 0; r <= nRetry; r++) begin
        busGrant = 1;
        if (killOnGrant && r == 0) begin extSnoopValid = 1; extSnoopLine = line; end
        @(negedge clk);
        busGrant = 0; extSnoopValid = 0;
        if (killOnGrant && r == 0 && mLine == line) mResv = 0;
        chk(busReq == 0, "R14", busReq, 0);
        snoopDone = 1; snoopRetry = (r < nRetry); snoopShared = shrd;
        @(negedge clk);
        snoopDone = 0; snoopRetry = 0; snoopShared = 0;
        if (r < nRetry) begin
          if (op == SC && !(mResv && mLine == line)) begin
            chkResp(0, 1, 0, 0, SI, "R11");
            mResv = 0;
            break;
          end
          chk(busReq == 1 && busType == code && !respValid, "R11", busType, code);
        end else begin
          if (op == LR) begin
            chkResp(0, 0, 0, 1, shrd ? SS : SE, tag);
            mResv = 1; mLine = line;
          end else begin
            chkResp(0, 1, 1, code == 5'b11110, SM, tag);
            mResv = 0;
          end
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 1, "R1", reqReady, 1);
    chk(busReq == 0 && respValid == 0, "R1", {busReq, respValid}, 0);
    runReq(SC, 3'd1, 0, 0, 1, SM, 0, 0, 0);      // R1 R7: nothing reserved
    runReq(LR, 3'd2, 0, 0, 1, SI, 0, 0, 0);      // R2 R3
    runReq(SC, 3'd2, 0, 0, 0, SI, 0, 1, 0);      // R8 shared still M
    runReq(SC, 3'd2, 0, 0, 0, SE, 0, 0, 0);      // R13: cleared by prior SC
    runReq(LR, 3'd3, 0, 0, 1, SI, 0, 1, 0);      // R4
    runReq(LR, 3'd4, 0, 0, 1, SM, 0, 0, 0);      // R5
    snoopOther(3'd5);                            // R12 other line
    runReq(SC, 3'd4, 0, 0, 1, SE, 0, 0, 0);      // R9
    runReq(LR, 3'd5, 0, 0, 1, SS, 0, 0, 0);      // R5
    snoopOther(3'd5);                            // R12 same line
    runReq(SC, 3'd5, 0, 0, 1, SS, 0, 0, 0);      // R12 -> fail
    runReq(LR, 3'd6, 0, 0, 1, SS, 0, 0, 0);
    runReq(LR, 3'd6, 1, 0, 1, SS, 0, 0, 0);      // R6 keeps reservation
    runReq(LR, 3'd6, 0, 1, 1, SI, 0, 0, 0);      // R6 inhibited
    runReq(SC, 3'd6, 1, 0, 1, SS, 0, 0, 0);      // R10
    runReq(LR, 3'd7, 0, 0, 0, SI, 2, 0, 0);      // R11 two retries
    runReq(SC, 3'd7, 0, 0, 0, SI, 1, 0, 1);      // R11 lost reservation
    runReq(LR, 3'd0, 0, 0, 1, SI, 0, 0, 0);
    runReq(SC, 3'd0, 0, 0, 1, SS, 1, 1, 0);      // R11 then R8
    runReq(LR, 3'd0, 0, 0, 1, SE, 0, 0, 0);
    runReq(SC, 3'd0, 0, 1, 1, SE, 0, 0, 1);      // R10 kill without retry: success
    for (int i = 0; i < 400; i++) begin
      logic [LW-1:0] ln = LW'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) snoopOther(LW'($urandom_range(0, 7)));
      runReq(($urandom_range(0, 1) == 0) ? LR : SC,
             ($urandom_range(0, 1) == 0 && mResv) ? mLine : ln,
             $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
             1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             $urandom_range(0, 2), 1'($urandom_range(0, 1)),
             $urandom_range(0, 5) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule